// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Framing-Error Flag

This block is the receive half of a microcontroller-style serial port. It samples the serial input line with a 16x oversampling tick supplied from outside. Each received frame goes into a receive buffer, and a receive-interrupt flag is raised. Frames carry 8 data bits, or 9 data bits where the ninth is kept as a separate flag. The receiver shares nothing with any transmitter, so it may run at its own baud rate.

Stop-bit checking can be turned on with an external enable. While it is on, a stop bit sampled as 0 sets a framing-error flag that only software or reset can clear. The most significant bit of the control register then reads and writes that flag instead of the upper mode-select bit. The receive flag is also raised one bit later, at the stop-bit sample rather than after the last data bit. Software reaches the control register and the buffer through a small register bus with one address bit.

Top module: `uart_rx_fe`

## Requirements
- R1: Control register (reg_addr=0) bits: 7 = upper mode bit M1 (or error flag, see R7), 6 = lower mode bit M0, 4 = receive enable, 2 = ninth-bit flag, 0 = receive flag; other bits read 0. {M1,M0}=01 receives 8 data bits, 10 and 11 receive 9 data bits with the ninth stored in bit 2, 00 receives nothing. The buffer reads at reg_addr=1, and bus writes to it are ignored.
- R2: A falling edge of the synchronised line starts a frame. The start is confirmed only if the majority of oversamples 7, 8 and 9 is 0. A one-tick low glitch returns the receiver to idle without a frame, and it can then receive again.
- R3: Every data bit and the stop bit is the majority of oversamples 7, 8 and 9 of its bit period. Data arrives least significant bit first.
- R4: When fe_en=1, a stop bit sampled as 0 sets the framing-error flag. When fe_en=0, no frame changes that flag.
- R5: The framing-error flag is sticky. Later frames with a valid stop bit leave it set. Only a control write with bit 7 = 0 while fe_en=1, or reset, clears it.
- R6: With fe_en=0 the receive flag rises at the last data bit's sample point, before the stop bit. With fe_en=1 it rises at the stop bit's sample point.
- R7: With fe_en=1, bit 7 of the control register reads and writes the error flag, and M1 is unchanged. With fe_en=0, bit 7 reads and writes M1.
- R8: With the receive enable at 0, no frame is received and the receive flag stays 0.
- R9: A frame that completes while the receive flag is 1 is discarded, and the buffer and ninth-bit flag keep their values. With fe_en=1 such a frame still sets the error flag if its stop bit is 0.
- R10: The receive flag (also driven on rx_irq) is cleared only by a control write with bit 0 = 0. Writing 1 to bit 0 has no effect.
- R11: The buffer and the ninth-bit flag change in the same cycle that the receive flag rises, and at no other time.
- R12: After reset, the control register reads 0x00, the buffer reads 0x00 and rx_irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| fe_en | input | 1 | Enables stop-bit checking and the bit-7 alias |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = receive buffer |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| rx_irq | output | 1 | Receive flag |

## Verification
The hardest case to reach is an overrun frame with a bad stop bit while checking is on. From the ports, that frame must be discarded while the sticky error flag still records its error. The bench first leaves a good frame unacknowledged, so the receive flag stays high. It then sends a second frame whose stop bit is held low, and reads back both the untouched buffer and the error flag through the bit-7 alias. Timing of the receive flag is checked by sampling rx_irq a few ticks into the stop-bit period. At that point the flag must already be set when checking is off, and must still be clear when checking is on.

// File: rtl/uart_rx_fe.sv
module uart_rx_fe #(
  parameter int OSR = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic       fe_en,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       rx_irq
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_prev;
  st_t                    st_q;
  logic [CW-1:0]          tick_q;
  logic [3:0]             bit_q;
  logic [1:0]             smp_q;
  logic [8:0]             sh_q;
  logic [7:0]             buf_q;
  logic sm0_q, sm1_q, ren_q, rb8_q, ri_q, fe_q;

  wire       rx_s     = sync_q[SYNC_STAGES-1];
  wire       nine     = sm0_q;
  wire       mode_ok  = sm0_q | sm1_q;
  wire       ctl_wr   = reg_wr & ~reg_addr;
  wire       at_vote  = baud_tick && (tick_q == CW'(MID + 1));
  wire       bit_end  = baud_tick && (tick_q == CW'(OSR - 1));
  wire       maj      = (smp_q[1] & smp_q[0]) | (smp_q[1] & rx_s) | (smp_q[0] & rx_s);
  wire [3:0] last_bit = nine ? 4'd8 : 4'd7;
  wire       data_done = (st_q == S_DATA) && at_vote && (bit_q == last_bit);
  wire       stop_seen = (st_q == S_STOP) && at_vote;
  wire       deliver  = ren_q & ~ri_q & (fe_en ? stop_seen : data_done);
  wire       fe_set   = ren_q & fe_en & stop_seen & ~maj;
  wire [8:0] frame    = fe_en ? sh_q : (sh_q | (9'(maj) << bit_q));

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[5], reg_wdata[3:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '1;
      rx_prev <= 1'b1;
      st_q    <= S_IDLE;
      tick_q  <= '0;
      bit_q   <= '0;
      smp_q   <= '1;
      sh_q    <= '0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], rxd};
      rx_prev <= rx_s;
      if (baud_tick) smp_q <= {smp_q[0], rx_s};
      if (st_q != S_IDLE && baud_tick) tick_q <= bit_end ? '0 : tick_q + CW'(1);
      case (st_q)
        S_IDLE:
          if (mode_ok && rx_prev && !rx_s) begin
            st_q   <= S_START;
            tick_q <= '0;
            sh_q   <= '0;
          end
        S_START:
          if (at_vote && maj) st_q <= S_IDLE;
          else if (bit_end) begin
            st_q  <= S_DATA;
            bit_q <= '0;
          end
        S_DATA: begin
          if (at_vote) sh_q[bit_q] <= maj;
          if (bit_end) begin
            if (bit_q == last_bit) st_q <= S_STOP;
            else bit_q <= bit_q + 4'd1;
          end
        end
        S_STOP:
          if (at_vote) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
      if (!ren_q || !mode_ok) st_q <= S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sm0_q <= 1'b0;
      sm1_q <= 1'b0;
      ren_q <= 1'b0;
      rb8_q <= 1'b0;
      ri_q  <= 1'b0;
      fe_q  <= 1'b0;
      buf_q <= '0;
    end else begin
      if (ctl_wr) begin
        if (fe_en) fe_q <= reg_wdata[7];
        else       sm0_q <= reg_wdata[7];
        sm1_q <= reg_wdata[6];
        ren_q <= reg_wdata[4];
        if (!reg_wdata[0]) ri_q <= 1'b0;
      end
      if (deliver) begin
        ri_q  <= 1'b1;
        buf_q <= frame[7:0];
        if (nine) rb8_q <= frame[8];
      end
      if (fe_set) fe_q <= 1'b1;
    end
  end

  assign reg_rdata = reg_addr ? buf_q
                   : {(fe_en ? fe_q : sm0_q), sm1_q, 1'b0, ren_q, 1'b0, rb8_q, 1'b0, ri_q};
  assign rx_irq = ri_q;
endmodule

// File: rtl/uart_rx_fe_chk.sv
module uart_rx_fe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_addr,
  input logic       wbit0,
  input logic       wbit7,
  input logic       fe_en,
  input logic       ri,
  input logic       fe,
  input logic       ren,
  input logic       rb8,
  input logic [7:0] rbuf
);
  p_ri_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ri && !(reg_wr && !reg_addr && !wbit0) |=> ri);

  p_fe_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fe && !(reg_wr && !reg_addr && fe_en && !wbit7) |=> fe);

  p_overrun_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ri |=> $stable(rbuf) && $stable(rb8));

  p_buf_atomic_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rbuf) |-> $rose(ri));

  p_no_rx_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ren |=> !$rose(ri));
endmodule

bind uart_rx_fe uart_rx_fe_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wbit0(reg_wdata[0]), .wbit7(reg_wdata[7]), .fe_en(fe_en),
  .ri(ri_q), .fe(fe_q), .ren(ren_q), .rb8(rb8_q), .rbuf(buf_q)
);

// File: tb/uart_rx_fe_tb_top.sv
module uart_rx_fe_tb_top;
  localparam int BIT_CLKS = 64;
  localparam int NROWS = 7;
  // {mode[1:0], fe_en, stop, data[8:0], exp_rb8, exp_fe, exp_early_ri}
  localparam logic [15:0] VEC [NROWS] = '{
    {2'b01, 1'b0, 1'b1, 9'h0A5, 1'b0, 1'b0, 1'b1},
    {2'b10, 1'b0, 1'b1, 9'h13C, 1'b1, 1'b0, 1'b1},
    {2'b11, 1'b1, 1'b1, 9'h05A, 1'b0, 1'b0, 1'b0},
    {2'b11, 1'b1, 1'b0, 9'h1FF, 1'b1, 1'b1, 1'b0},
    {2'b01, 1'b0, 1'b0, 9'h081, 1'b1, 1'b0, 1'b1},
    {2'b01, 1'b1, 1'b0, 9'h0C3, 1'b1, 1'b1, 1'b0},
    {2'b10, 1'b1, 1'b1, 9'h001, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, baud_tick, rxd = 1'b1, fe_en = 1'b0;
  logic reg_wr = 1'b0, reg_addr = 1'b0, rx_irq;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [1:0] tdiv = '0;
  int total = 0, bad = 0, cyc = 0;
  logic seen, early;
  logic [7:0] cap, d;

  always #2 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign baud_tick = (tdiv == 2'd0);

  uart_rx_fe dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd), .fe_en(fe_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_irq(rx_irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 1'b1;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
    reg_addr = 1'b1;
  endtask

  task automatic rd_fe(output logic v);
    logic s;
    logic [7:0] t;
    s = fe_en; fe_en = 1'b1; rd(1'b0, t); v = t[7]; fe_en = s;
  endtask

  task automatic drive(logic b, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxd = b;
      #1 if (rx_irq && !seen) begin seen = 1'b1; cap = reg_rdata; end
    end
  endtask

  task automatic send(int nb, logic [8:0] dat, logic stopb);
    reg_addr = 1'b1; seen = 1'b0;
    drive(1'b0, BIT_CLKS);
    for (int i = 0; i < nb; i++) drive(dat[i], BIT_CLKS);
    drive(stopb, 12);
    early = rx_irq;
    drive(stopb, BIT_CLKS - 12);
    drive(1'b1, 32);
  endtask

  task automatic setup(logic [1:0] m, logic ren, logic fen);
    fe_en = 1'b1; wr(1'b0, 8'h00);
    fe_en = 1'b0; wr(1'b0, {m, 1'b0, ren, 4'b0});
    fe_en = fen;
  endtask

  initial begin
    logic v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd(1'b0, d); chk("R12 ctrl", 9'(d), 9'h00);
    rd(1'b1, d); chk("R12 buf", 9'(d), 9'h00);
    chk("R12 irq", 9'(rx_irq), 9'h0);

    // R10: writing 1 to the receive flag does nothing
    wr(1'b0, 8'h01); chk("R10 set by write", 9'(rx_irq), 9'h0);

    for (int r = 0; r < NROWS; r++) begin
      logic [15:0] e;
      e = VEC[r];
      setup(e[15:14], 1'b1, e[13]);
      send(e[15] ? 9 : 8, e[11:3], e[12]);
      chk("R6 early ri", 9'(early), 9'(e[0]));
      chk("R10 irq", 9'(rx_irq), 9'h1);
      chk("R11 buf at ri", 9'(cap), 9'(e[10:3]));
      rd(1'b1, d); chk("R1 R3 buf", 9'(d), 9'(e[10:3]));
      rd(1'b0, d); chk("R1 rb8", 9'(d[2]), 9'(e[2]));
      rd_fe(v); chk("R4 fe", 9'(v), 9'(e[1]));
    end

    // R10: write with bit0=1 keeps, bit0=0 clears
    fe_en = 1'b0;
    wr(1'b0, 8'h91); chk("R10 keep", 9'(rx_irq), 9'h1);
    wr(1'b0, 8'h90); chk("R10 clear", 9'(rx_irq), 9'h0);

    // R9: overrun with bad stop still flags error
    setup(2'b01, 1'b1, 1'b1);
    send(8, 9'h011, 1'b1);
    send(8, 9'h022, 1'b0);
    rd(1'b1, d); chk("R9 buf kept", 9'(d), 9'h011);
    rd_fe(v); chk("R9 fe on overrun", 9'(v), 9'h1);

    // R5: sticky error flag
    wr(1'b0, 8'hD0);
    send(8, 9'h033, 1'b1);
    rd(1'b1, d); chk("R5 buf", 9'(d), 9'h033);
    rd_fe(v); chk("R5 sticky", 9'(v), 9'h1);
    wr(1'b0, 8'h50);
    rd_fe(v); chk("R5 cleared", 9'(v), 9'h0);

    // R7: bit 7 alias
    setup(2'b01, 1'b1, 1'b1);
    wr(1'b0, 8'hD0);
    fe_en = 1'b0; rd(1'b0, d); chk("R7 M1 untouched", 9'(d[7]), 9'h0);
    fe_en = 1'b1; rd(1'b0, d); chk("R7 reads fe", 9'(d[7]), 9'h1);

    // R8: receive disabled
    setup(2'b01, 1'b0, 1'b0);
    send(8, 9'h0EE, 1'b1);
    chk("R8 no irq", 9'(rx_irq), 9'h0);
    rd(1'b1, d); chk("R8 buf kept", 9'(d), 9'h033);

    // R1: mode 00 receives nothing
    setup(2'b00, 1'b1, 1'b0);
    send(8, 9'h0AB, 1'b1);
    chk("R1 mode0 no irq", 9'(rx_irq), 9'h0);

    // R2: glitch rejected, then normal frame
    setup(2'b01, 1'b1, 1'b0);
    drive(1'b0, 4);
    drive(1'b1, 20 * BIT_CLKS);
    chk("R2 glitch", 9'(rx_irq), 9'h0);
    send(8, 9'h05C, 1'b1);
    rd(1'b1, d); chk("R2 R3 after glitch", 9'(d), 9'h05C);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule